// File: doc/BRIEF.md
# DMA Channel Condition Evaluator

This block decides three things about the descriptor a DMA channel is working on: whether to raise an interrupt, whether to take a branch, and whether to stall and wait. Each decision has its own select register, which holds a 4-bit mask and a 4-bit compare value. That select register is matched against the four live device-status bits of the channel, and the command word of the descriptor supplies a 2-bit policy that says how the match is used.

Software, or a sequencer, loads the three select registers over a simple write-only register port. The channel engine presents the device-status bits and the command word, then pulses an evaluate strobe. One clock later the three decisions appear together with a one-cycle valid pulse. The decisions then hold until the next strobe.

Top module: `cev_cond_eval`

## Requirements
- R1: A write with `sel_wr_en` high loads one select register: address 0 is the interrupt select, 1 is the branch select and 2 is the wait select. The mask is taken from data bits [19:16] and the compare value from bits [3:0]. All other data bits have no effect on any decision.
- R2: The condition of a decision is true when (status AND mask) equals (value AND mask). Only the 4 device-status bits and that decision's own select register are used.
- R3: The policy code 00 means never, 01 means fire when the condition is true, 10 means fire when the condition is false, and 11 means always. Codes 00 and 11 give their result whatever the condition is.
- R4: The command word carries the interrupt policy in bits [5:4], the branch policy in bits [3:2] and the wait policy in bits [1:0]. Bits [15:6] have no effect.
- R5: The three decisions are independent. Each one uses only its own select register and its own policy field.
- R6: The decisions update on the first clock edge after an evaluate strobe, and `result_valid` is high for exactly that one cycle. Without a strobe the decisions hold their values and `result_valid` stays low.
- R7: Reset clears all select registers and all outputs. With the registers cleared, every mask is zero and every condition is true.
- R8: A select write and an evaluate strobe in the same cycle: the evaluation uses the register contents from before the write. The new contents apply from the next strobe onward.
- R9: A write to address 3 changes no select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_en | input | 1 | Select register write enable |
| sel_wr_addr | input | 2 | Select register index |
| sel_wr_data | input | 32 | Select register write data |
| dev_status | input | 4 | Live device-status bits of the channel |
| cmd_word | input | 16 | Descriptor command word holding the three policies |
| eval_strobe | input | 1 | Evaluate the current descriptor |
| irq_fire | output | 1 | Interrupt decision |
| take_branch | output | 1 | Branch decision |
| must_wait | output | 1 | Wait decision |
| result_valid | output | 1 | One-cycle pulse when the decisions are refreshed |

## Verification
Two functions can meet in one clock cycle: a select-register load, and an evaluation that reads that same register. The bench provokes this by writing a new mask and value to the interrupt select while it pulses the strobe, with a status that matches the new contents but not the old ones. The expected decision is taken from the bench's model before the model applies the write. A follow-up strobe must then show the new contents in effect.

// File: rtl/cev_pkg.sv
package cev_pkg;

   typedef enum logic [1:0] {
      POL_NEVER    = 2'b00,
      POL_IF_TRUE  = 2'b01,
      POL_IF_FALSE = 2'b10,
      POL_ALWAYS   = 2'b11
   } pol_e;

   localparam int NUM_DEC  = 3;
   localparam int DEC_IRQ  = 0;
   localparam int DEC_BR   = 1;
   localparam int DEC_WAIT = 2;

   function automatic logic apply_policy(input pol_e pol, input logic cond);
      logic res;
      case (pol)
         POL_NEVER:    res = 1'b0;
         POL_IF_TRUE:  res = cond;
         POL_IF_FALSE: res = !cond;
         default:      res = 1'b1;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/cev_sel_bank.sv
module cev_sel_bank #(
   parameter int NUM_SEL  = 3,
   parameter int DATA_W   = 32,
   parameter int FIELD_W  = 4,
   parameter int MASK_LSB = 16,
   parameter int VAL_LSB  = 0,
   parameter int ADDR_W   = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [NUM_SEL-1:0][FIELD_W-1:0]  mask_o,
   output logic [NUM_SEL-1:0][FIELD_W-1:0]  val_o
);

   localparam logic [DATA_W-1:0] FIELD_ONES = DATA_W'((1 << FIELD_W) - 1);
   localparam logic [DATA_W-1:0] USED_BITS  =
      (FIELD_ONES << MASK_LSB) | (FIELD_ONES << VAL_LSB);

   if (MASK_LSB + FIELD_W > DATA_W || VAL_LSB + FIELD_W > DATA_W) begin : g_bad_pos
      $error("cev_sel_bank: field lies outside the data word");
   end
   if ((1 << ADDR_W) < NUM_SEL) begin : g_bad_addr
      $error("cev_sel_bank: address too narrow for register count");
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^(wr_data & ~USED_BITS);

   logic [NUM_SEL-1:0][FIELD_W-1:0] mask_q;
   logic [NUM_SEL-1:0][FIELD_W-1:0] val_q;

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[i] <= '0;
            val_q[i]  <= '0;
         end else if (hit) begin
            mask_q[i] <= wr_data[MASK_LSB +: FIELD_W];
            val_q[i]  <= wr_data[VAL_LSB  +: FIELD_W];
         end
      end

      // R5: a write aimed at another index leaves this register alone
      p_other_addr_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr != ADDR_W'(i)) |=> ($stable(mask_q[i]) && $stable(val_q[i])));
   end

   assign mask_o = mask_q;
   assign val_o  = val_q;

   // R9: an index with no register behind it changes nothing
   p_unused_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= ADDR_W'(NUM_SEL)) |=> ($stable(mask_q) && $stable(val_q)));

   // R1: a write lands the mask and value fields in the addressed register
   p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(0)) |=>
         (mask_q[0] == $past(wr_data[MASK_LSB +: FIELD_W]) &&
          val_q[0]  == $past(wr_data[VAL_LSB +: FIELD_W])));

endmodule

// File: rtl/cev_decide.sv
module cev_decide
   import cev_pkg::*;
#(
   parameter int STAT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval,
   input  logic [STAT_W-1:0] status,
   input  logic [STAT_W-1:0] sel_mask,
   input  logic [STAT_W-1:0] sel_val,
   input  logic [1:0]        policy,
   output logic              decision
);

   if (STAT_W < 1) begin : g_bad_w
      $error("cev_decide: status width must be positive");
   end

   logic cond;
   logic dec_next;
   logic dec_q;
   pol_e pol;

   assign pol      = pol_e'(policy);
   assign cond     = ((status ^ sel_val) & sel_mask) == '0;
   assign dec_next = apply_policy(pol, cond);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dec_q <= 1'b0;
      else if (eval) dec_q <= dec_next;
   end

   assign decision = dec_q;

   // R3: never and always ignore the condition
   p_never_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && policy == 2'b00) |=> !decision);
   p_always_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && policy == 2'b11) |=> decision);

   // R2: an empty mask makes the condition true
   p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && sel_mask == '0 && policy == 2'b01) |=> decision);

   // R6: without a strobe the decision holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> $stable(decision));

endmodule

// File: rtl/cev_cond_eval.sv
module cev_cond_eval
   import cev_pkg::*;
#(
   parameter int STAT_W   = 4,
   parameter int SEL_W    = 32,
   parameter int MASK_LSB = 16,
   parameter int VAL_LSB  = 0,
   parameter int CMD_W    = 16,
   parameter int INTR_LSB = 4,
   parameter int BR_LSB   = 2,
   parameter int WAIT_LSB = 0,
   parameter int ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr_en,
   input  logic [ADDR_W-1:0] sel_wr_addr,
   input  logic [SEL_W-1:0]  sel_wr_data,
   input  logic [STAT_W-1:0] dev_status,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              eval_strobe,
   output logic              irq_fire,
   output logic              take_branch,
   output logic              must_wait,
   output logic              result_valid
);

   localparam int POL_W = 2;
   localparam logic [CMD_W-1:0] POL_ONES = CMD_W'((1 << POL_W) - 1);
   localparam logic [CMD_W-1:0] POL_BITS =
      (POL_ONES << INTR_LSB) | (POL_ONES << BR_LSB) | (POL_ONES << WAIT_LSB);

   if (INTR_LSB + POL_W > CMD_W || BR_LSB + POL_W > CMD_W || WAIT_LSB + POL_W > CMD_W)
   begin : g_bad_cmd
      $error("cev_cond_eval: policy field outside the command word");
   end

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^(cmd_word & ~POL_BITS);

   logic [NUM_DEC-1:0][STAT_W-1:0] sel_mask;
   logic [NUM_DEC-1:0][STAT_W-1:0] sel_val;
   logic [NUM_DEC-1:0]             dec;

   cev_sel_bank #(
      .NUM_SEL  (NUM_DEC),
      .DATA_W   (SEL_W),
      .FIELD_W  (STAT_W),
      .MASK_LSB (MASK_LSB),
      .VAL_LSB  (VAL_LSB),
      .ADDR_W   (ADDR_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel_wr_en),
      .wr_addr (sel_wr_addr),
      .wr_data (sel_wr_data),
      .mask_o  (sel_mask),
      .val_o   (sel_val)
   );

   for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
      localparam int FLD = (d == DEC_IRQ) ? INTR_LSB :
                           (d == DEC_BR)  ? BR_LSB   : WAIT_LSB;
      cev_decide #(.STAT_W(STAT_W)) u_decide (
         .clk      (clk),
         .rst_n    (rst_n),
         .eval     (eval_strobe),
         .status   (dev_status),
         .sel_mask (sel_mask[d]),
         .sel_val  (sel_val[d]),
         .policy   (cmd_word[FLD +: POL_W]),
         .decision (dec[d])
      );
   end

   logic valid_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= eval_strobe;
   end

   assign irq_fire     = dec[DEC_IRQ];
   assign take_branch  = dec[DEC_BR];
   assign must_wait    = dec[DEC_WAIT];
   assign result_valid = valid_q;

   // R6: valid is a one-cycle echo of the strobe
   p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eval_strobe |=> result_valid);
   p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_strobe |=> !result_valid);

   // R4: always-policy in the interrupt field fires the interrupt
   p_intr_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_strobe && cmd_word[INTR_LSB +: POL_W] == 2'b11) |=> irq_fire);

endmodule

// File: tb/tb_cev_cond_eval.sv
module tb_cev_cond_eval;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_wr_en = 1'b0;
   logic [1:0]  sel_wr_addr = '0;
   logic [31:0] sel_wr_data = '0;
   logic [3:0]  dev_status = '0;
   logic [15:0] cmd_word = '0;
   logic        eval_strobe = 1'b0;
   logic        irq_fire, take_branch, must_wait, result_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   cev_cond_eval dut (
      .clk(clk), .rst_n(rst_n),
      .sel_wr_en(sel_wr_en), .sel_wr_addr(sel_wr_addr), .sel_wr_data(sel_wr_data),
      .dev_status(dev_status), .cmd_word(cmd_word), .eval_strobe(eval_strobe),
      .irq_fire(irq_fire), .take_branch(take_branch), .must_wait(must_wait),
      .result_valid(result_valid)
   );

   typedef struct {
      logic [2:0] exp;   // {irq, branch, wait}
      string      tag;
   } item_t;

   item_t q[$];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [3:0] bm [3];
   logic [3:0] bv [3];

   function automatic logic model(input logic [1:0] p, input logic [3:0] st,
                                  input logic [3:0] m, input logic [3:0] v);
      logic c;
      c = ((st & m) == (v & m));
      case (p)
         2'b00: return 1'b0;
         2'b01: return c;
         2'b10: return !c;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [2:0] expect3(input logic [3:0] st, input logic [15:0] cmd);
      return {model(cmd[5:4], st, bm[0], bv[0]),
              model(cmd[3:2], st, bm[1], bv[1]),
              model(cmd[1:0], st, bm[2], bv[2])};
   endfunction

   function automatic logic [31:0] pack_sel(input logic [3:0] m, input logic [3:0] v);
      return {12'hABC, m, 12'h5E7, v};
   endfunction

   task automatic model_write(input logic [1:0] a, input logic [31:0] d);
      if (a != 2'd3) begin
         bm[a] = d[19:16];
         bv[a] = d[3:0];
      end
   endtask

   task automatic sel_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      eval_strobe = 1'b0;
      sel_wr_en = 1'b1; sel_wr_addr = a; sel_wr_data = d;
      model_write(a, d);
      @(negedge clk);
      sel_wr_en = 1'b0;
   endtask

   task automatic do_eval(input logic [3:0] st, input logic [15:0] cmd, input string tag);
      item_t it;
      @(negedge clk);
      sel_wr_en = 1'b0;
      dev_status = st; cmd_word = cmd; eval_strobe = 1'b1;
      it.exp = expect3(st, cmd);
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      eval_strobe = 1'b0;
      sel_wr_en = 1'b0;
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && result_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R6 unexpected valid", 32'd1, 32'd0);
         end else begin
            item_t it;
            it = q.pop_front();
            check({irq_fire, take_branch, must_wait} == it.exp, it.tag,
                  {29'd0, irq_fire, take_branch, must_wait}, {29'd0, it.exp});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] held;
      for (int i = 0; i < 3; i++) begin bm[i] = '0; bv[i] = '0; end
      repeat (3) @(negedge clk);
      // R7: reset state at the ports
      check({irq_fire, take_branch, must_wait, result_valid} == 4'b0, "R7 reset outputs",
            {28'd0, irq_fire, take_branch, must_wait, result_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(result_valid == 1'b0, "R7 valid after reset", {31'd0, result_valid}, 32'd0);

      // R7: cleared selects give a true condition everywhere
      do_eval(4'b1010, 16'h0015, "R7 zero mask if-true");
      do_eval(4'b0110, 16'h002A, "R7 zero mask if-false");
      idle();

      // R9: unused index leaves registers unchanged
      sel_write(2'd3, pack_sel(4'hF, 4'h0));
      do_eval(4'hF, 16'h0015, "R9 write to index 3 ignored");
      idle();

      // R6: hold with no strobe
      do_eval(4'h0, 16'h0034, "R6 setup");   // irq always, branch if-true, wait never
      idle();
      @(negedge clk);
      held = {irq_fire, take_branch, must_wait};
      for (int k = 0; k < 3; k++) begin
         dev_status = 4'(k * 5); cmd_word = 16'(k * 16'h0111);
         @(negedge clk);
         check({irq_fire, take_branch, must_wait} == held && !result_valid, "R6 hold",
               {28'd0, irq_fire, take_branch, must_wait, result_valid}, {28'd0, held, 1'b0});
      end

      // R8: write and evaluate in the same cycle
      sel_write(2'd0, pack_sel(4'hF, 4'h0));
      @(negedge clk);
      begin
         item_t it;
         sel_wr_en = 1'b1; sel_wr_addr = 2'd0; sel_wr_data = pack_sel(4'hF, 4'hF);
         dev_status = 4'hF; cmd_word = 16'h0010; eval_strobe = 1'b1;
         it.exp = expect3(4'hF, 16'h0010);
         it.tag = "R8 same-cycle uses old select";
         q.push_back(it);
         model_write(2'd0, pack_sel(4'hF, 4'hF));
      end
      do_eval(4'hF, 16'h0010, "R8 new select applies next");
      idle();

      // R1 R2 R3 R4 R5: every mask, value, status and policy
      for (int m = 0; m < 16; m++) begin
         for (int v = 0; v < 16; v++) begin
            sel_write(2'd0, pack_sel(4'(m), 4'(v)));
            sel_write(2'd1, pack_sel(4'(v), 4'(m)));
            sel_write(2'd2, pack_sel(~4'(m), 4'(m ^ v)));
            for (int s = 0; s < 16; s++) begin
               for (int p = 0; p < 4; p++) begin
                  logic [15:0] cmd;
                  cmd = {4'(s), 6'(p * 11 + m), 2'(p), 2'(p + 1), 2'(p + 2)};
                  do_eval(4'(s), cmd, "R1 R2 R3 R4 R5 sweep");
               end
            end
         end
      end
      idle();
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R6 all results seen", q.size(), 32'd0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule